// File: doc/BRIEF.md
# Serial-to-Parallel Receiver with Word Realignment

This block takes a one-bit serial stream, sampled on the rising edge of a fast serial clock, and assembles it into parallel words of 4, 6, 7, 8 or 10 bits. The word width is picked by a small code that is held steady while the block runs and is changed only under reset. An internal phase counter, driven by the chosen width, produces a load strobe. The strobe copies the running shift register into an output word register and raises a one-cycle valid flag beside it.

Framing logic upstream can move the word boundary at run time. It sends a single-cycle slip pulse, and each accepted pulse delays the serial stream by one more bit. Further pulses are refused until two words have been loaded, which gives the new alignment time to show up in the data before it is judged again. A separate bypass setting routes the input around the deserializer and into plain capture registers. These work at one bit per clock, or at two bits per clock when the falling edge is also used. Slip pulses have no effect while bypass is on.

Top module: `serdes_slip_rx`

## Requirements
- R1: `ratio_sel` picks the word width: code 0 gives 4, 1 gives 6, 2 gives 7, 3 gives 8, 4 gives 10, and codes 5 to 7 behave as 10. The code changes only while `rst` is high.
- R2: A deserialized word holds the F bits sampled on F consecutive rising edges. The earliest bit sits in bit F-1 and the latest in bit 0. Bits F and above read zero.
- R3: After reset is released, `par_valid` stays low for the first F-1 rising edges. It then pulses for one cycle after the F-th edge, carrying the first word, and pulses again every F edges after that.
- R4: Each accepted slip pulse adds one bit of delay to the stream. For an input that repeats with period F, the word seen after s accepted slips equals the zero-slip word rotated right by s positions within its F bits.
- R5: After F accepted slips, the alignment returns to its original position.
- R6: A slip pulse that arrives before two words have been loaded since the last accepted slip is ignored.
- R7: Slip pulses are ignored while `bypass_en` is high. The alignment in use after bypass is left is the one in use before it was entered.
- R8: Single-rate bypass (`bypass_en`=1, `ddr_en`=0): after each rising edge, `par_data[0]` holds the bit sampled on that edge, every other bit is zero, and `par_valid` is high.
- R9: Double-rate bypass (`bypass_en`=1, `ddr_en`=1): after each rising edge, `par_data[1]` holds the bit sampled on the preceding falling edge, `par_data[0]` holds the bit sampled on that rising edge, the other bits are zero, and `par_valid` is high.
- R10: A synchronous active-high `rst` clears the word, the valid flag, the shift register, the delay history and the slip count, and restarts the load phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial-rate clock; both edges are used in double-rate bypass |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 3 | Word-width code, changed only under reset |
| bypass_en | input | 1 | Route input around the deserializer |
| ddr_en | input | 1 | In bypass, also capture on the falling edge |
| ser_in | input | 1 | Serial data input |
| slip_req | input | 1 | Single-cycle request to move the word boundary by one bit |
| par_data | output | 10 | Parallel word, or bypass capture bits |
| par_valid | output | 1 | High for one cycle with each new word; held high in bypass |

## Verification
The bench sends a repeating pattern for every width code, including an out-of-range code that must act as width 10. It slips through every rotation and back to the start. A design that miscounted slips, or wrapped at the wrong count, would show a wrongly rotated word at the wrap or one step before it. A second slip sent straight after an accepted one must leave the rotation unchanged; a design without the hold-off would show one rotation too many. A slip sent during bypass must leave the rotation in place when bypass is left. The bench also checks the exact edge of the first strobe after reset, where an off-by-one load counter would deliver a shifted first word. In double-rate bypass it checks the bit order, which a design that swapped the edges would reverse.

// File: rtl/srx_pkg.sv
package srx_pkg;

    // Widest legal word; sets the width of every phase and slip counter.
    localparam int unsigned RATIO_MAX = 10;
    localparam int unsigned CNT_W     = $clog2(RATIO_MAX + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        RATIO_4  = 3'd0,
        RATIO_6  = 3'd1,
        RATIO_7  = 3'd2,
        RATIO_8  = 3'd3,
        RATIO_10 = 3'd4
    } ratio_code_e;

    // Map a width code to the word width; unused codes fall back to the widest.
    function automatic cnt_t ratio_width(input logic [2:0] code);
        cnt_t w;
        case (code)
            RATIO_4:  w = cnt_t'(4);
            RATIO_6:  w = cnt_t'(6);
            RATIO_7:  w = cnt_t'(7);
            RATIO_8:  w = cnt_t'(8);
            default:  w = cnt_t'(RATIO_MAX);
        endcase
        return w;
    endfunction

endpackage

// File: rtl/srx_load_gen.sv
module srx_load_gen
    import srx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cnt_t ratio,
    output logic load_o
);

    typedef struct packed {
        cnt_t phase;
    } lg_state_t;

    lg_state_t st_d, st_q;
    logic      last_phase;

    always_comb begin
        last_phase = (st_q.phase == ratio - cnt_t'(1));
        st_d       = st_q;
        if (last_phase) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + cnt_t'(1);
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign load_o = last_phase && !rst;

    // Independent gap watcher: counts edges since reset or the last strobe.
    cnt_t gap_q;
    always_ff @(posedge clk) begin
        if (rst || load_o) begin
            gap_q <= '0;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + cnt_t'(1);
        end
    end

    assert_load_gap_R3: assert property (@(posedge clk) disable iff (rst)
        load_o |-> (gap_q == ratio - cnt_t'(1)));

    assert_load_due_R3: assert property (@(posedge clk) disable iff (rst)
        gap_q < ratio);

endmodule

// File: rtl/srx_slip_ctrl.sv
module srx_slip_ctrl
    import srx_pkg::*;
#(
    parameter int unsigned WORD_W     = 10,
    parameter int unsigned HOLD_LOADS = 2
) (
    input  logic clk,
    input  logic rst,
    input  cnt_t ratio,
    input  logic slip_req,
    input  logic bypass,
    input  logic load,
    input  logic ser_in,
    output logic ser_aligned
);

    localparam int unsigned HOLD_W = $clog2(HOLD_LOADS + 1);

    typedef struct packed {
        logic [WORD_W-2:0] hist;   // hist[k] is the input bit k+1 cycles ago
        cnt_t              slips;  // current added delay in bits
        logic [HOLD_W-1:0] hold;   // loads still to pass before a new slip
    } sc_state_t;

    sc_state_t         st_d, st_q;
    logic              accept;
    logic [WORD_W-1:0] taps;

    always_comb begin
        st_d   = st_q;
        accept = slip_req && !bypass && (st_q.hold == '0);
        st_d.hist = {st_q.hist[WORD_W-3:0], ser_in};
        if (accept) begin
            if (st_q.slips == ratio - cnt_t'(1)) begin
                st_d.slips = '0;
            end else begin
                st_d.slips = st_q.slips + cnt_t'(1);
            end
            st_d.hold = HOLD_W'(HOLD_LOADS);
        end else if (load && (st_q.hold != '0)) begin
            st_d.hold = st_q.hold - 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Delay-line tap: zero slips takes the live bit, s slips the bit s cycles old.
    assign taps        = {st_q.hist, ser_in};
    assign ser_aligned = taps[st_q.slips];

    assert_slip_cause_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.slips) |-> $past(slip_req));

    assert_slip_range_R5: assert property (@(posedge clk) disable iff (rst)
        st_q.slips < ratio);

    assert_holdoff_R6: assert property (@(posedge clk) disable iff (rst)
        (slip_req && (st_q.hold != '0)) |=> $stable(st_q.slips));

    assert_bypass_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (slip_req && bypass) |=> $stable(st_q.slips));

endmodule

// File: rtl/srx_fall_cap.sv
module srx_fall_cap (
    input  logic clk,
    input  logic rst,
    input  logic ser_in,
    output logic fall_bit
);

    typedef struct packed {
        logic bit_v;
    } fc_state_t;

    fc_state_t st_d, st_q;

    always_comb begin
        st_d.bit_v = rst ? 1'b0 : ser_in;
    end

    always_ff @(negedge clk) begin
        st_q <= st_d;
    end

    assign fall_bit = st_q.bit_v;

endmodule

// File: rtl/serdes_slip_rx.sv
module serdes_slip_rx
    import srx_pkg::*;
#(
    parameter int unsigned WORD_W     = 10,
    parameter int unsigned HOLD_LOADS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        ratio_sel,
    input  logic              bypass_en,
    input  logic              ddr_en,
    input  logic              ser_in,
    input  logic              slip_req,
    output logic [WORD_W-1:0] par_data,
    output logic              par_valid
);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] word;
        logic              valid;
    } rx_state_t;

    rx_state_t         st_d, st_q;
    cnt_t              ratio;
    logic              load;
    logic              ser_aligned;
    logic              fall_bit;
    logic [WORD_W-1:0] word_mask;

    assign ratio = ratio_width(ratio_sel);

    always_comb begin
        for (int i = 0; i < WORD_W; i++) begin
            word_mask[i] = (i < int'(ratio));
        end
    end

    srx_load_gen u_load (
        .clk    (clk),
        .rst    (rst),
        .ratio  (ratio),
        .load_o (load)
    );

    srx_slip_ctrl #(
        .WORD_W     (WORD_W),
        .HOLD_LOADS (HOLD_LOADS)
    ) u_slip (
        .clk         (clk),
        .rst         (rst),
        .ratio       (ratio),
        .slip_req    (slip_req),
        .bypass      (bypass_en),
        .load        (load),
        .ser_in      (ser_in),
        .ser_aligned (ser_aligned)
    );

    srx_fall_cap u_fall (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .fall_bit (fall_bit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.shreg = {st_q.shreg[WORD_W-2:0], ser_aligned};
        st_d.valid = 1'b0;
        if (bypass_en) begin
            st_d.valid   = 1'b1;
            st_d.word    = '0;
            st_d.word[0] = ser_in;
            if (ddr_en) begin
                st_d.word[1] = fall_bit;
            end
        end else if (load) begin
            st_d.valid = 1'b1;
            st_d.word  = st_d.shreg & word_mask;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign par_data  = st_q.word;
    assign par_valid = st_q.valid;

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (par_data == '0) && !par_valid);

    assert_word_narrow_R2: assert property (@(posedge clk) disable iff (rst)
        (par_valid && !$past(bypass_en)) |-> ((par_data & ~word_mask) == '0));

    assert_bypass_valid_R8: assert property (@(posedge clk) disable iff (rst)
        bypass_en |=> par_valid);

    assert_sdr_upper_R8: assert property (@(posedge clk) disable iff (rst)
        (bypass_en && !ddr_en) |=> (par_data[WORD_W-1:1] == '0));

endmodule

// File: tb/serdes_slip_rx_test.sv
module serdes_slip_rx_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 6;

    // {width code, expected width, repeating pattern sent earliest bit first}
    localparam logic [16:0] VECS [NVEC] = '{
        {3'd0, 4'd4,  10'b0000000111},
        {3'd1, 4'd6,  10'b0000110100},
        {3'd2, 4'd7,  10'b0001011000},
        {3'd3, 4'd8,  10'b0011010010},
        {3'd4, 4'd10, 10'b1101001100},
        {3'd6, 4'd10, 10'b1011100010}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] ratio_sel = 3'd0;
    logic       bypass_en = 1'b0;
    logic       ddr_en = 1'b0;
    logic       ser_in = 1'b0;
    logic       slip_req = 1'b0;
    logic [9:0] par_data;
    logic       par_valid;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    int         cur_f = 4;
    logic [9:0] cur_pat = '0;
    int         bit_k = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serdes_slip_rx uut (
        .clk       (clk),
        .rst       (rst),
        .ratio_sel (ratio_sel),
        .bypass_en (bypass_en),
        .ddr_en    (ddr_en),
        .ser_in    (ser_in),
        .slip_req  (slip_req),
        .par_data  (par_data),
        .par_valid (par_valid)
    );

    function automatic logic [9:0] rotr(input logic [9:0] v, input int f, input int s);
        logic [9:0] r;
        r = v;
        for (int k = 0; k < s; k++) begin
            r = (r >> 1) | ({9'b0, r[0]} << (f - 1));
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One rising edge, then drive the next pattern bit 2 time units later.
    task automatic tick();
        @(posedge clk);
        #2;
        ser_in = cur_pat[cur_f - 1 - (bit_k % cur_f)];
        bit_k++;
    endtask

    task automatic do_reset(input logic [2:0] code);
        ratio_sel = code;
        bypass_en = 1'b0;
        ddr_en    = 1'b0;
        slip_req  = 1'b0;
        rst       = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check(par_data == '0 && !par_valid, "R10 reset clear", par_data, 10'h0);
        rst    = 1'b0;
        ser_in = cur_pat[cur_f - 1];
        bit_k  = 1;
    endtask

    task automatic wait_word(input string req);
        int n;
        n = 0;
        while (!par_valid && n < 2 * cur_f) begin
            tick();
            n++;
        end
        if (!par_valid) begin
            check(1'b0, req, {9'b0, par_valid}, 10'h1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R3: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int v = 0; v < NVEC; v++) begin
            logic [16:0] e;
            e       = VECS[v];
            cur_f   = int'(e[13:10]);
            cur_pat = e[9:0];
            do_reset(e[16:14]);

            // R1 / R3: first strobe lands exactly on the F-th edge
            for (int k = 1; k <= cur_f; k++) begin
                tick();
                if (k < cur_f) begin
                    check(!par_valid, "R3 no early strobe", {9'b0, par_valid}, 10'h0);
                end else begin
                    check(par_valid, "R1 R3 first strobe", {9'b0, par_valid}, 10'h1);
                    check(par_data == cur_pat, "R2 first word", par_data, cur_pat);
                end
            end
            repeat (cur_f - 1) tick();
            check(!par_valid, "R3 strobe gap", {9'b0, par_valid}, 10'h0);
            tick();
            check(par_valid && par_data == cur_pat, "R3 second word", par_data, cur_pat);

            // R4 / R5 / R6: walk every rotation and back to the start
            for (int s = 1; s <= cur_f; s++) begin
                slip_req = 1'b1;
                tick();
                slip_req = 1'b0;
                if (s == 1) begin
                    tick();
                    slip_req = 1'b1;   // inside hold-off: must be refused (R6)
                    tick();
                    slip_req = 1'b0;
                end
                repeat (3 * cur_f) tick();
                wait_word("R4 word after slip");
                if (s == cur_f) begin
                    check(par_data == cur_pat, "R5 wrap to origin", par_data, cur_pat);
                end else begin
                    check(par_data == rotr(cur_pat, cur_f, s),
                          (s == 1) ? "R4 R6 one slip only" : "R4 rotation",
                          par_data, rotr(cur_pat, cur_f, s));
                end
            end

            // R7: slip during bypass has no lasting effect
            bypass_en = 1'b1;
            tick();
            slip_req = 1'b1;
            tick();
            slip_req = 1'b0;
            repeat (2) tick();
            check(par_valid, "R8 bypass valid", {9'b0, par_valid}, 10'h1);
            bypass_en = 1'b0;
            repeat (3 * cur_f) tick();
            wait_word("R7 word after bypass");
            check(par_data == cur_pat, "R7 slip ignored in bypass", par_data, cur_pat);
        end

        // R8: single-rate bypass
        cur_f   = 8;
        cur_pat = 10'b0011010010;
        do_reset(3'd3);
        bypass_en = 1'b1;
        for (int i = 0; i < 12; i++) begin
            logic b;
            b = ((16'hB4E3 >> i) & 16'h1) != 0;
            ser_in = b;
            @(posedge clk);
            #2;
            check(par_valid && par_data == {9'b0, b}, "R8 single-rate capture",
                  par_data, {9'b0, b});
        end

        // R9: double-rate bypass, falling-edge bit in position 1
        ddr_en = 1'b1;
        for (int i = 0; i < 12; i++) begin
            logic a;
            logic b;
            a = ((16'h6C1D >> i) & 16'h1) != 0;
            b = ((16'h93A5 >> i) & 16'h1) != 0;
            ser_in = a;
            #5;
            ser_in = b;
            @(posedge clk);
            #2;
            check(par_valid && par_data == {8'b0, a, b}, "R9 double-rate capture",
                  par_data, {8'b0, a, b});
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule